// File: doc/BRIEF.md
# Spread Spectrum Modulation Profile Controller

This block produces the frequency-offset profile of a spread spectrum clock synthesizer. It runs on the reference clock. Each cycle it emits a signed offset word in units of 0.01 percent, which a fractional feedback divider uses to steer the synthesized frequency. The profile is a symmetric triangle centred on the nominal frequency, so the mean offset over a period is zero. One full sweep, from minimum up to maximum and back to minimum, takes a fixed 2332 reference cycles whatever the setting. A one-cycle marker flags the start of each sweep.

The sweep amplitude is chosen by two selection inputs. Each one has three levels (low, middle, high) and arrives pre-decoded as a 2-bit code. A band index names the reference frequency sub-band. The same selection means a different amplitude in each sub-band, and some selections are only meaningful in the lower or only in the upper frequency range. An enable input stops modulation and forces the offset to zero. On re-enable the sweep restarts from its zero crossing on the rising slope.

Top module: `ssc_profile_ctrl`

## Requirements
- R1: `period_start` is high for exactly one cycle, in the cycle whose phase is 0, where the offset is at its minimum. While enabled, consecutive markers are exactly 2332 cycles apart.
- R2: While enabled with a valid selection, the phase p advances by one each cycle and wraps from 2331 to 0. The offset is trunc((2t − 1166)·A / 1166), rounded toward zero, where t = p for p < 1166 and t = 2332 − p otherwise, and A is the selected amplitude.
- R3: A cycle with `spread_en` low gives zero offset and no marker at the next clock edge. The first enabled cycle after that has phase 583 (offset 0), and the offset then rises.
- R4: Each selection code maps as follows: 00 = low, 01 = middle, 10 = high, and the unused value 11 = middle.
- R5: Band indices 0..3 are the low sub-bands (50–60, 60–70, 70–80, 80–100 MHz). Their valid (A,B) selections, from widest to narrowest, have these amplitudes per sub-band 0..3: (M,M) 215/200/190/175; (M,L) 195/180/170/155; (H,L) 165/155/145/135; (L,L) 145/130/125/110; (L,M) 135/125/120/105.
- R6: Band indices 4..12 are the upper sub-bands (100–120 MHz, then 10 MHz steps up to 200 MHz). Their valid selections have these amplitudes per index 4..12: (H,M) 150/135/130/130/125/120/120/115/115; (L,H) 120/105/100/100/90/90/90/85/80; (H,H) 80/70/65/65/60/60/60/55/55; (M,H) 65/55/55/55/50/50/50/45/45.
- R7: A selection that is not valid for the current band, or a band index of 13..15, gives zero offset and raises `code_invalid` at the next edge. The phase keeps advancing meanwhile.
- R8: During and straight after reset the offset is zero and `period_start` and `code_invalid` are low. The phase is set so that the first enabled cycle is at phase 583.
- R9: Over any full period between two markers (marker cycle included, next marker excluded), the offsets sum to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spread_en | input | 1 | Modulation enable; low forces zero offset |
| sel_a_code | input | 2 | First three-level selection, 2-bit code |
| sel_b_code | input | 2 | Second three-level selection, 2-bit code |
| band_sel | input | BAND_W (4) | Reference frequency sub-band index |
| freq_offset | output | OFS_W (12) | Signed frequency offset, 0.01 % units |
| period_start | output | 1 | One-cycle marker at sweep start (minimum) |
| code_invalid | output | 1 | Selection not valid for the band |

## Verification
The hardest thing to bring about from the ports is an amplitude lookup that a wrong table entry would actually change. Near the zero crossing, amplitudes that differ by a few units give the same truncated offset. The bench therefore runs the sweep until its phase is just below the peak. It then steps through all 56 valid band/selection pairs, one per cycle, so that every lookup is seen at about 0.95 of its amplitude. A second hard case is the restart point after a disable. The bench drops the enable in the middle of the sweep and checks the exact sequence that follows the restart.

// File: rtl/ssc_pkg.sv
`timescale 1ns/1ps
package ssc_pkg;

    localparam int SSC_AMP_W    = 8;
    localparam int SSC_LO_BANDS = 4;
    localparam int SSC_HI_BANDS = 9;
    localparam int SSC_MAX_AMP  = 215;

    typedef enum logic [1:0] {
        LVL_LO  = 2'd0,
        LVL_MID = 2'd1,
        LVL_HI  = 2'd2
    } lvl_e;

    function automatic lvl_e to_lvl(input logic [1:0] code);
        case (code)
            2'b00:   return LVL_LO;
            2'b10:   return LVL_HI;
            default: return LVL_MID;
        endcase
    endfunction

endpackage

// File: rtl/ssc_phase_gen.sv
`timescale 1ns/1ps
module ssc_phase_gen #(
    parameter int PERIOD = 2332
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run,
    output logic [$clog2(PERIOD)-1:0]  phase_nxt
);
    localparam int PH_W = $clog2(PERIOD);
    localparam int HALF = PERIOD / 2;
    localparam int ZERO = HALF / 2;

    typedef struct packed {
        logic [PH_W-1:0] ph;
    } ph_st_t;

    ph_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run) begin
            st_d.ph = (st_q.ph == PH_W'(PERIOD - 1)) ? '0 : st_q.ph + 1'b1;
        end else begin
            st_d.ph = PH_W'(ZERO - 1);
        end
        phase_nxt = st_d.ph;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph <= PH_W'(ZERO - 1);
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ssc_sel_decode.sv
`timescale 1ns/1ps
module ssc_sel_decode import ssc_pkg::*; #(
    parameter int BAND_W = 4
) (
    input  logic [1:0]            sel_a_code,
    input  logic [1:0]            sel_b_code,
    input  logic [BAND_W-1:0]     band_sel,
    output logic [SSC_AMP_W-1:0]  amp,
    output logic                  valid
);
    localparam int AW = SSC_AMP_W;

    function automatic logic [AW-1:0] lo_amp(input logic [2:0] rank, input logic [1:0] sub);
        logic [4*AW-1:0] row;
        case (rank)
            3'd0:    row = {8'd175, 8'd190, 8'd200, 8'd215};
            3'd1:    row = {8'd155, 8'd170, 8'd180, 8'd195};
            3'd2:    row = {8'd135, 8'd145, 8'd155, 8'd165};
            3'd3:    row = {8'd110, 8'd125, 8'd130, 8'd145};
            default: row = {8'd105, 8'd120, 8'd125, 8'd135};
        endcase
        return row[sub*AW +: AW];
    endfunction

    function automatic logic [AW-1:0] hi_amp(input logic [1:0] rank, input logic [3:0] sub);
        logic [9*AW-1:0] row;
        case (rank)
            2'd0:    row = {8'd115, 8'd115, 8'd120, 8'd120, 8'd125, 8'd130, 8'd130, 8'd135, 8'd150};
            2'd1:    row = {8'd80,  8'd85,  8'd90,  8'd90,  8'd90,  8'd100, 8'd100, 8'd105, 8'd120};
            2'd2:    row = {8'd55,  8'd55,  8'd60,  8'd60,  8'd60,  8'd65,  8'd65,  8'd70,  8'd80};
            default: row = {8'd45,  8'd45,  8'd50,  8'd50,  8'd50,  8'd55,  8'd55,  8'd55,  8'd65};
        endcase
        return row[sub*AW +: AW];
    endfunction

    lvl_e            lvl_a, lvl_b;
    logic [3:0]      hi_sub;
    logic [BAND_W-1:0] band_off;

    always_comb begin
        lvl_a    = to_lvl(sel_a_code);
        lvl_b    = to_lvl(sel_b_code);
        band_off = band_sel - BAND_W'(SSC_LO_BANDS);
        hi_sub   = 4'(band_off);
        amp      = '0;
        valid    = 1'b0;
        if (band_sel < BAND_W'(SSC_LO_BANDS)) begin
            valid = 1'b1;
            case ({lvl_a, lvl_b})
                {LVL_MID, LVL_MID}: amp = lo_amp(3'd0, band_sel[1:0]);
                {LVL_MID, LVL_LO }: amp = lo_amp(3'd1, band_sel[1:0]);
                {LVL_HI,  LVL_LO }: amp = lo_amp(3'd2, band_sel[1:0]);
                {LVL_LO,  LVL_LO }: amp = lo_amp(3'd3, band_sel[1:0]);
                {LVL_LO,  LVL_MID}: amp = lo_amp(3'd4, band_sel[1:0]);
                default:            valid = 1'b0;
            endcase
        end else if (band_sel < BAND_W'(SSC_LO_BANDS + SSC_HI_BANDS)) begin
            valid = 1'b1;
            case ({lvl_a, lvl_b})
                {LVL_HI,  LVL_MID}: amp = hi_amp(2'd0, hi_sub);
                {LVL_LO,  LVL_HI }: amp = hi_amp(2'd1, hi_sub);
                {LVL_HI,  LVL_HI }: amp = hi_amp(2'd2, hi_sub);
                {LVL_MID, LVL_HI }: amp = hi_amp(2'd3, hi_sub);
                default:            valid = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/ssc_tri_shape.sv
`timescale 1ns/1ps
module ssc_tri_shape import ssc_pkg::*; #(
    parameter int PERIOD = 2332,
    parameter int OFS_W  = 12
) (
    input  logic [$clog2(PERIOD)-1:0] phase,
    input  logic [SSC_AMP_W-1:0]      amp,
    output logic signed [OFS_W-1:0]   offset
);
    localparam int PH_W  = $clog2(PERIOD);
    localparam int HALF  = PERIOD / 2;
    localparam int NUM_W = PH_W + SSC_AMP_W + 3;

    logic [PH_W-1:0]          tpos;
    logic signed [NUM_W-1:0]  lin, num;

    always_comb begin
        tpos   = (phase < PH_W'(HALF)) ? phase : PH_W'(PERIOD) - phase;
        lin    = $signed(NUM_W'({tpos, 1'b0})) - $signed(NUM_W'(HALF));
        num    = lin * $signed(NUM_W'(amp));
        offset = OFS_W'(num / $signed(NUM_W'(HALF)));
    end

endmodule

// File: rtl/ssc_profile_ctrl.sv
`timescale 1ns/1ps
module ssc_profile_ctrl import ssc_pkg::*; #(
    parameter int PERIOD = 2332,
    parameter int OFS_W  = 12,
    parameter int BAND_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     spread_en,
    input  logic [1:0]               sel_a_code,
    input  logic [1:0]               sel_b_code,
    input  logic [BAND_W-1:0]        band_sel,
    output logic signed [OFS_W-1:0]  freq_offset,
    output logic                     period_start,
    output logic                     code_invalid
);
    localparam int PH_W = $clog2(PERIOD);

    typedef struct packed {
        logic signed [OFS_W-1:0] ofs;
        logic                    start;
        logic                    bad;
    } out_st_t;

    logic [PH_W-1:0]          phase_nxt;
    logic [SSC_AMP_W-1:0]     amp;
    logic                     sel_ok;
    logic signed [OFS_W-1:0]  shaped;
    out_st_t                  st_d, st_q;

    ssc_phase_gen #(.PERIOD(PERIOD)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (spread_en),
        .phase_nxt (phase_nxt)
    );

    ssc_sel_decode #(.BAND_W(BAND_W)) u_decode (
        .sel_a_code (sel_a_code),
        .sel_b_code (sel_b_code),
        .band_sel   (band_sel),
        .amp        (amp),
        .valid      (sel_ok)
    );

    ssc_tri_shape #(.PERIOD(PERIOD), .OFS_W(OFS_W)) u_shape (
        .phase  (phase_nxt),
        .amp    (amp),
        .offset (shaped)
    );

    always_comb begin
        st_d       = st_q;
        st_d.ofs   = (spread_en && sel_ok) ? shaped : '0;
        st_d.start = spread_en && (phase_nxt == '0);
        st_d.bad   = !sel_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign freq_offset  = st_q.ofs;
    assign period_start = st_q.start;
    assign code_invalid = st_q.bad;

endmodule

// File: rtl/ssc_profile_chk.sv
`timescale 1ns/1ps
module ssc_profile_chk import ssc_pkg::*; #(
    parameter int PERIOD = 2332,
    parameter int OFS_W  = 12,
    parameter int BAND_W = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     spread_en,
    input logic [1:0]               sel_a_code,
    input logic [1:0]               sel_b_code,
    input logic [BAND_W-1:0]        band_sel,
    input logic signed [OFS_W-1:0]  freq_offset,
    input logic                     period_start,
    input logic                     code_invalid
);
    localparam int GW = $clog2(PERIOD) + 1;

    logic [GW-1:0] gap_q;
    logic          seen_q;
    logic [BAND_W+3:0] sel_bus;

    assign sel_bus = {sel_a_code, sel_b_code, band_sel};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (!spread_en) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (period_start) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    AST_MARK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (period_start && seen_q && spread_en) |-> (gap_q == GW'(PERIOD - 1))); // R1

    AST_MARK_AT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (period_start && !code_invalid) |-> (freq_offset < 0)); // R1

    AST_SLEW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (spread_en && $past(spread_en) && !code_invalid && !$past(code_invalid)
         && ($past(sel_bus, 1) == $past(sel_bus, 2)))
        |-> ((freq_offset <= $past(freq_offset) + 1) && (freq_offset >= $past(freq_offset) - 1))); // R2

    AST_OFF_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !spread_en |=> (freq_offset == 0 && !period_start)); // R3

    AST_AMP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_offset <= SSC_MAX_AMP) && (freq_offset >= -SSC_MAX_AMP)); // R5

    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        code_invalid |-> (freq_offset == 0)); // R7

endmodule

bind ssc_profile_ctrl ssc_profile_chk #(
    .PERIOD (PERIOD),
    .OFS_W  (OFS_W),
    .BAND_W (BAND_W)
) i_ssc_profile_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .spread_en    (spread_en),
    .sel_a_code   (sel_a_code),
    .sel_b_code   (sel_b_code),
    .band_sel     (band_sel),
    .freq_offset  (freq_offset),
    .period_start (period_start),
    .code_invalid (code_invalid)
);

// File: tb/test_ssc_profile_ctrl.sv
`timescale 1ns/1ps
module test_ssc_profile_ctrl;
    localparam int PERIOD = 2332;
    localparam int HALF   = 1166;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               en = 1'b1;
    logic [1:0]         sa = 2'b01;
    logic [1:0]         sb = 2'b01;
    logic [3:0]         band = 4'd0;
    logic signed [11:0] freq_offset;
    logic               period_start;
    logic               code_invalid;

    int ph = 582;
    int checks = 0;
    int errors = 0;

    int lo_tab [5][4] = '{'{215,200,190,175}, '{195,180,170,155}, '{165,155,145,135},
                          '{145,130,125,110}, '{135,125,120,105}};
    int lo_a [5] = '{1,1,2,0,0};
    int lo_b [5] = '{1,0,0,0,1};
    int hi_tab [4][9] = '{'{150,135,130,130,125,120,120,115,115},
                          '{120,105,100,100,90,90,90,85,80},
                          '{80,70,65,65,60,60,60,55,55},
                          '{65,55,55,55,50,50,50,45,45}};
    int hi_a [4] = '{2,0,2,1};
    int hi_b [4] = '{1,2,2,2};

    ssc_profile_ctrl i_ssc_profile_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .spread_en    (en),
        .sel_a_code   (sa),
        .sel_b_code   (sb),
        .band_sel     (band),
        .freq_offset  (freq_offset),
        .period_start (period_start),
        .code_invalid (code_invalid)
    );

    always #2.5 clk = ~clk;

    function automatic int lvl(input logic [1:0] c);
        return (c == 2'b00) ? 0 : ((c == 2'b10) ? 2 : 1);
    endfunction

    function automatic logic [1:0] enc(input int l);
        return (l == 0) ? 2'b00 : ((l == 2) ? 2'b10 : 2'b01);
    endfunction

    function automatic int amp_exp();
        int la = lvl(sa);
        int lb = lvl(sb);
        if (band < 4) begin
            for (int r = 0; r < 5; r++)
                if (la == lo_a[r] && lb == lo_b[r]) return lo_tab[r][band];
        end else if (band < 13) begin
            for (int r = 0; r < 4; r++)
                if (la == hi_a[r] && lb == hi_b[r]) return hi_tab[r][band-4];
        end
        return -1;
    endfunction

    function automatic int tri_exp(input int p, input int a);
        int t = (p < HALF) ? p : PERIOD - p;
        return ((2 * t - HALF) * a) / HALF;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        if (en) ph = (ph == PERIOD - 1) ? 0 : ph + 1;
        else    ph = 582;
        @(negedge clk);
    endtask

    task automatic check_all(input string req);
        int a = amp_exp();
        int e = (en && a >= 0) ? tri_exp(ph, a) : 0;
        chk(req, "offset", int'(freq_offset), e);
        chk(req, "marker", int'(period_start), int'(en && ph == 0));
        chk(req, "invalid", int'(code_invalid), int'(a < 0));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8", "offset in reset", int'(freq_offset), 0);
        chk("R8", "marker in reset", int'(period_start), 0);
        chk("R8", "invalid in reset", int'(code_invalid), 0);
        rst_n = 1'b1;
        ph = 582;
        cyc();
        chk("R8", "first phase offset", int'(freq_offset), 0);
        check_all("R8");
    endtask

    task automatic t_full_sweep();
        int last = -1;
        int sum = 0;
        en = 1'b0;
        repeat (3) begin
            cyc();
            check_all("R3");
        end
        en = 1'b1;
        cyc();
        chk("R3", "restart offset", int'(freq_offset), 0);
        for (int i = 0; i < 3 * PERIOD; i++) begin
            cyc();
            check_all("R2");
            if (period_start) begin
                if (last >= 0) begin
                    chk("R1", "marker gap", i - last, PERIOD);
                    chk("R9", "period sum", sum, 0);
                end
                chk("R1", "offset at marker", int'(freq_offset), -215);
                last = i;
                sum = 0;
            end
            sum += int'(freq_offset);
        end
    endtask

    task automatic t_disable_midrun();
        en = 1'b0;
        cyc();
        chk("R3", "disabled offset", int'(freq_offset), 0);
        check_all("R3");
        en = 1'b1;
        cyc();
        chk("R3", "re-enable offset", int'(freq_offset), 0);
        check_all("R3");
        for (int i = 0; i < 120; i++) begin
            cyc();
            check_all("R3");
        end
        chk("R3", "rising after restart", int'(freq_offset > 0), 1);
    endtask

    task automatic t_tables();
        while (ph != 1139) cyc();
        for (int b = 0; b < 4; b++)
            for (int r = 0; r < 5; r++) begin
                sa = enc(lo_a[r]); sb = enc(lo_b[r]); band = 4'(b);
                cyc();
                check_all("R5");
            end
        for (int b = 0; b < 9; b++)
            for (int r = 0; r < 4; r++) begin
                sa = enc(hi_a[r]); sb = enc(hi_b[r]); band = 4'(b + 4);
                cyc();
                check_all("R6");
            end
    endtask

    task automatic t_codes();
        sa = 2'b11; sb = 2'b11; band = 4'd0;
        cyc();
        check_all("R4");
        sa = 2'b11; sb = 2'b00; band = 4'd1;
        cyc();
        check_all("R4");
        sa = 2'b10; sb = 2'b11; band = 4'd6;
        cyc();
        check_all("R4");
    endtask

    task automatic t_invalid();
        sa = 2'b10; sb = 2'b10; band = 4'd0;
        cyc();
        chk("R7", "flag high-band code in low band", int'(code_invalid), 1);
        check_all("R7");
        sa = 2'b01; sb = 2'b01; band = 4'd5;
        cyc();
        check_all("R7");
        sa = 2'b10; sb = 2'b01; band = 4'd13;
        cyc();
        chk("R7", "flag band out of range", int'(code_invalid), 1);
        check_all("R7");
        sa = 2'b01; sb = 2'b01; band = 4'd2;
        cyc();
        check_all("R7");
        cyc();
        check_all("R7");
    endtask

    initial begin
        t_reset();
        t_full_sweep();
        t_disable_midrun();
        t_tables();
        t_codes();
        t_invalid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #750000;
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule